// File: doc/BRIEF.md
# Frame-Buffer Header Decoder and Palette

This block sits behind the memory fetch of a raster display path. It takes the 32-bit words read from the start of a frame buffer, reorders the byte lanes as configured and splits each word into two 16-bit entries. The first entry of a frame carries the pixel-format code in its upper bits. The header entries are written into an on-chip colour palette. Once the header is used up, the remaining words go to a pixel unpacker. The unpacker hands out one 12-bit colour per request, either looked up in the palette or taken directly from the word.

The length of the header is not set by any configuration. It follows from the format code found in memory: a long header for 8 bits per pixel and a short one for every other code. A load-mode input, sampled when a frame starts, selects one of three modes. The first reads the header and then pixel data. The second reads the header and stops. The third skips the header and reuses the format and palette already held.

Top module: `fb_header_palette`

## Requirements
- R1: After reset, and until the first `frame_start`, `in_ready`, `pix_avail`, `pix_valid` and `pal_loaded` are low and `cur_fmt` is 0; a `pix_req` in that time produces no pixel.
- R2: Byte lane k is bits 8k+7:8k. `cfg_lane_order` picks the source lane for output lanes 0,1,2,3: code 0 gives 0,1,2,3; code 1 gives 1,0,2,3; code 2 gives 3,2,1,0; code 3 gives 2,3,0,1. Headers and pixel data are reordered the same way.
- R3: Within a reordered word, bits 15:0 form the earlier entry and bits 31:16 the later one. Bits 14:12 of the first entry of a frame are the format code: 0, 1, 2 and 3 mean 1, 2, 4 and 8 bits per pixel, and 4 to 7 mean direct colour. The code appears on `cur_fmt` from the cycle after that word is accepted. Bits 15:12 of every other entry have no effect.
- R4: The header is 128 words (256 entries) when the code is 3 and 8 words (16 entries) for any other code. In the header-plus-data mode (`cfg_load_mode` 0 or 3), the next accepted word is pixel data.
- R5: `pal_loaded` is high for exactly one cycle, the cycle after the last header word is accepted, and at no other time.
- R6: In palette-only mode (`cfg_load_mode` 1), `in_ready` and `pix_avail` stay low after the header until the next `frame_start`.
- R7: In data-only mode (`cfg_load_mode` 2), every word is pixel data, `pal_loaded` never rises, and the format and palette entries left by the previous load are used unchanged.
- R8: In a palettised format, a data word gives 32/bpp pixels, starting at bit 0. Each pixel is the index of a palette entry, and the colour output is bits 11:0 of that entry.
- R9: In direct colour, each 16-bit half of a data word is one pixel, low half first, and the colour output is bits 11:0 of that half.
- R10: A `pix_req` while `pix_avail` is high yields `pix_valid` with the colour in the following cycle. A `pix_req` while `pix_avail` is low is ignored. `pix_avail` goes low once the last pixel of a word is requested.
- R11: The loaded count is the number of entries written since the last header began. A palette index at or above that count reads entry 0.
- R12: `frame_start` discards any partly consumed data word (`pix_avail` low the next cycle), abandons a header in progress, and restarts in the mode on `cfg_load_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Begin a new frame load, sampling `cfg_load_mode` |
| cfg_load_mode | input | 2 | 0/3 header then data, 1 header only, 2 data only |
| cfg_lane_order | input | 2 | Byte-lane reordering code |
| in_valid | input | 1 | Fetched word present |
| in_data | input | 32 | Fetched word, memory byte order |
| in_ready | output | 1 | Block accepts the word this cycle |
| pix_req | input | 1 | Request the next pixel |
| pix_avail | output | 1 | A pixel can be requested |
| pix_valid | output | 1 | Colour valid, one cycle after an accepted request |
| pix_color | output | 12 | Pixel colour, 4 bits per channel |
| cur_fmt | output | 3 | Format code in use |
| pal_loaded | output | 1 | One-cycle pulse when the header is used up |

## Verification
A wrong header word count or format latch shows up at once: `pal_loaded` rises on the wrong word, or the first data word is taken as a palette entry, so the colours after the header are wrong from the first pixel. A palette bank or address error shows on the first request whose index hits the bad entry, one cycle after that request. A wrong unpack position or step corrupts the second pixel of a word and changes when `pix_avail` falls. A failed abort leaves `pix_avail` high one cycle after `frame_start`.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;
  localparam int WORD_W  = 32;
  localparam int FMT_W   = 3;

  localparam logic [1:0] LD_FULL = 2'd0;
  localparam logic [1:0] LD_PAL  = 2'd1;
  localparam logic [1:0] LD_DATA = 2'd2;

  localparam logic [FMT_W-1:0] FMT_8BPP = 3'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA, ST_HOLD} hdr_state_e;

  // bit step per pixel for a format code; direct colour uses a 16-bit slot
  function automatic logic [4:0] step_of(input logic [FMT_W-1:0] fmt);
    case (fmt)
      3'd0:    step_of = 5'd1;
      3'd1:    step_of = 5'd2;
      3'd2:    step_of = 5'd4;
      3'd3:    step_of = 5'd8;
      default: step_of = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/fbp_lane_swap.sv
`timescale 1ns/1ps
module fbp_lane_swap
  import fbp_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  input  logic [1:0]        order,
  output logic [WORD_W-1:0] dout
);
  localparam int LANES = WORD_W / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [1:0] src;
    always_comb begin
      case (order)
        2'd1:    src = (k < 2) ? 2'(k ^ 1) : 2'(k);
        2'd2:    src = 2'(LANES - 1 - k);
        2'd3:    src = 2'(k ^ 2);
        default: src = 2'(k);
      endcase
    end
    assign dout[8*k +: 8] = din[8*src +: 8];
  end
endmodule

// File: rtl/fbp_pal_bank.sv
`timescale 1ns/1ps
module fbp_pal_bank #(
  parameter int AW = 7,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fbp_hdr_ctrl.sv
`timescale 1ns/1ps
module fbp_hdr_ctrl
  import fbp_pkg::*;
#(
  parameter int PAL_AW          = 8,
  parameter int SHORT_HDR_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [1:0]        ld_mode,
  input  logic              in_valid,
  input  logic [FMT_W-1:0]  fmt_field,
  input  logic              buf_free,
  output logic              in_ready,
  output logic              pal_we,
  output logic [PAL_AW-2:0] pal_waddr,
  output logic              data_load,
  output logic [FMT_W-1:0]  fmt_q,
  output logic [PAL_AW:0]   pal_cnt,
  output logic              pal_loaded
);
  localparam int BA = PAL_AW - 1;
  localparam logic [BA-1:0] LONG_LAST  = BA'((2 ** PAL_AW) / 2 - 1);
  localparam logic [BA-1:0] SHORT_LAST = BA'(SHORT_HDR_WORDS - 1);

  hdr_state_e      st;
  logic [1:0]      mode_q;
  logic [BA-1:0]   hw;
  logic            acc, last;
  logic [FMT_W-1:0] fmt_now;

  assign in_ready  = !frame_start &&
                     ((st == ST_HDR) || ((st == ST_DATA) && buf_free));
  assign acc       = in_valid && in_ready;
  assign fmt_now   = (hw == '0) ? fmt_field : fmt_q;
  assign last      = (hw == ((fmt_now == FMT_8BPP) ? LONG_LAST : SHORT_LAST));
  assign pal_we    = (st == ST_HDR) && acc;
  assign pal_waddr = hw;
  assign data_load = (st == ST_DATA) && acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mode_q     <= LD_FULL;
      hw         <= '0;
      fmt_q      <= '0;
      pal_cnt    <= '0;
      pal_loaded <= 1'b0;
    end else begin
      pal_loaded <= 1'b0;
      if (frame_start) begin
        mode_q <= ld_mode;
        hw     <= '0;
        if (ld_mode == LD_DATA) begin
          st <= ST_DATA;
        end else begin
          st      <= ST_HDR;
          pal_cnt <= '0;
        end
      end else if (pal_we) begin
        if (hw == '0) fmt_q <= fmt_field;
        pal_cnt <= pal_cnt + (PAL_AW+1)'(2);
        hw      <= hw + BA'(1);
        if (last) begin
          pal_loaded <= 1'b1;
          st         <= (mode_q == LD_PAL) ? ST_HOLD : ST_DATA;
        end
      end
    end
  end
endmodule

// File: rtl/fbp_unpacker.sv
`timescale 1ns/1ps
module fbp_unpacker
  import fbp_pkg::*;
#(
  parameter int PAL_AW  = 8,
  parameter int COLOR_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               load,
  input  logic [WORD_W-1:0]  word,
  input  logic [FMT_W-1:0]   fmt,
  input  logic               req,
  output logic               avail,
  output logic               fire,
  output logic [PAL_AW-1:0]  idx,
  output logic [COLOR_W-1:0] direct,
  output logic               is_direct
);
  logic [WORD_W-1:0]  wbuf;
  logic               wval;
  logic [4:0]         pos;
  logic [4:0]         step;
  logic [5:0]         nxt;
  logic [COLOR_W-1:0] sh;
  logic [PAL_AW-1:0]  mask;

  assign step      = step_of(fmt);
  assign nxt       = {1'b0, pos} + {1'b0, step};
  assign sh        = COLOR_W'(wbuf >> pos);
  assign avail     = wval;
  assign fire      = req && wval;
  assign is_direct = fmt[2];
  assign direct    = sh;

  always_comb begin
    if (step >= 5'(PAL_AW)) mask = '1;
    else                    mask = PAL_AW'((1 << step) - 1);
  end
  assign idx = sh[PAL_AW-1:0] & mask;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wval <= 1'b0;
      pos  <= '0;
    end else if (load) begin
      wbuf <= word;
      wval <= 1'b1;
      pos  <= '0;
    end else if (fire) begin
      if (nxt[5]) begin
        wval <= 1'b0;
        pos  <= '0;
      end else begin
        pos <= nxt[4:0];
      end
    end
  end
endmodule

// File: rtl/fb_header_palette.sv
`timescale 1ns/1ps
module fb_header_palette
  import fbp_pkg::*;
#(
  parameter int PAL_AW          = 8,
  parameter int COLOR_W         = 12,
  parameter int SHORT_HDR_WORDS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic [1:0]         cfg_load_mode,
  input  logic [1:0]         cfg_lane_order,
  input  logic               in_valid,
  input  logic [31:0]        in_data,
  output logic               in_ready,
  input  logic               pix_req,
  output logic               pix_avail,
  output logic               pix_valid,
  output logic [COLOR_W-1:0] pix_color,
  output logic [2:0]         cur_fmt,
  output logic               pal_loaded
);
  localparam int BANK_AW = PAL_AW - 1;
  localparam int ENT_W   = WORD_W / 2;

  logic [WORD_W-1:0]  sw;
  logic               pal_we, data_load;
  logic [BANK_AW-1:0] pal_waddr;
  logic [PAL_AW:0]    pal_cnt;
  logic               fire, is_direct;
  logic [PAL_AW-1:0]  idx, eff_idx;
  logic [COLOR_W-1:0] direct;
  logic [COLOR_W-1:0] bank_rd [2];
  logic               bank_sel_q, direct_sel_q, pv_q;
  logic [COLOR_W-1:0] direct_q;

  fbp_lane_swap u_swap (
    .din   (in_data),
    .order (cfg_lane_order),
    .dout  (sw)
  );

  fbp_hdr_ctrl #(
    .PAL_AW          (PAL_AW),
    .SHORT_HDR_WORDS (SHORT_HDR_WORDS)
  ) u_hdr (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .ld_mode     (cfg_load_mode),
    .in_valid    (in_valid),
    .fmt_field   (sw[14:12]),
    .buf_free    (!pix_avail),
    .in_ready    (in_ready),
    .pal_we      (pal_we),
    .pal_waddr   (pal_waddr),
    .data_load   (data_load),
    .fmt_q       (cur_fmt),
    .pal_cnt     (pal_cnt),
    .pal_loaded  (pal_loaded)
  );

  fbp_unpacker #(
    .PAL_AW  (PAL_AW),
    .COLOR_W (COLOR_W)
  ) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .flush     (frame_start),
    .load      (data_load),
    .word      (sw),
    .fmt       (cur_fmt),
    .req       (pix_req),
    .avail     (pix_avail),
    .fire      (fire),
    .idx       (idx),
    .direct    (direct),
    .is_direct (is_direct)
  );

  // indices past the loaded entry count fall back to entry 0
  assign eff_idx = ({1'b0, idx} < pal_cnt) ? idx : '0;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    fbp_pal_bank #(
      .AW (BANK_AW),
      .DW (COLOR_W)
    ) u_bank (
      .clk   (clk),
      .we    (pal_we),
      .waddr (pal_waddr),
      .wdata (sw[b*ENT_W +: COLOR_W]),
      .re    (fire && !is_direct),
      .raddr (eff_idx[PAL_AW-1:1]),
      .rdata (bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pv_q         <= 1'b0;
      bank_sel_q   <= 1'b0;
      direct_sel_q <= 1'b0;
      direct_q     <= '0;
    end else begin
      pv_q <= fire;
      if (fire) begin
        bank_sel_q   <= eff_idx[0];
        direct_sel_q <= is_direct;
        direct_q     <= direct;
      end
    end
  end

  assign pix_valid = pv_q;
  assign pix_color = direct_sel_q ? direct_q : bank_rd[bank_sel_q];
endmodule

// File: rtl/fb_header_palette_chk.sv
`timescale 1ns/1ps
module fb_header_palette_chk (
  input logic       clk,
  input logic       rst,
  input logic       frame_start,
  input logic [1:0] cfg_load_mode,
  input logic       in_ready,
  input logic       pix_req,
  input logic       pix_avail,
  input logic       pix_valid,
  input logic [2:0] cur_fmt,
  input logic       pal_loaded
);
  logic       started;
  logic [1:0] mode_q;
  logic       hdr_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      started  <= 1'b0;
      mode_q   <= 2'd0;
      hdr_done <= 1'b0;
    end else if (frame_start) begin
      started  <= 1'b1;
      mode_q   <= cfg_load_mode;
      hdr_done <= 1'b0;
    end else if (pal_loaded) begin
      hdr_done <= 1'b1;
    end
  end

  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !started |-> (!in_ready && !pix_avail)); // R1

  AST_PIX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (pix_req && pix_avail) |=> pix_valid); // R10

  AST_PIX_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(pix_req && pix_avail)); // R10

  AST_LOADED_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pal_loaded |=> !pal_loaded); // R5

  AST_PAL_ONLY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (started && mode_q == 2'd1 && hdr_done && !frame_start) |-> (!in_ready && !pix_avail)); // R6

  AST_DATA_ONLY_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    (started && mode_q == 2'd2) |-> !pal_loaded); // R7

  AST_DATA_ONLY_FMT_HELD: assert property (@(posedge clk) disable iff (rst)
    (started && mode_q == 2'd2 && !frame_start) |=> $stable(cur_fmt)); // R7

  AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !pix_avail); // R12
endmodule

bind fb_header_palette fb_header_palette_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .frame_start   (frame_start),
  .cfg_load_mode (cfg_load_mode),
  .in_ready      (in_ready),
  .pix_req       (pix_req),
  .pix_avail     (pix_avail),
  .pix_valid     (pix_valid),
  .cur_fmt       (cur_fmt),
  .pal_loaded    (pal_loaded)
);

// File: tb/fb_header_palette_bench.sv
`timescale 1ns/1ps
module fb_header_palette_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [1:0]  cfg_load_mode = 2'd0;
  logic [1:0]  cfg_lane_order = 2'd0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        pix_req = 1'b0;
  logic        pix_avail, pix_valid, pal_loaded;
  logic [11:0] pix_color;
  logic [2:0]  cur_fmt;

  int checks = 0;
  int errors = 0;

  logic [11:0] exp_pal [256];
  int          exp_cnt = 0;
  logic [2:0]  exp_fmt = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_header_palette u_fb_header_palette (
    .clk            (clk),
    .rst            (rst),
    .frame_start    (frame_start),
    .cfg_load_mode  (cfg_load_mode),
    .cfg_lane_order (cfg_lane_order),
    .in_valid       (in_valid),
    .in_data        (in_data),
    .in_ready       (in_ready),
    .pix_req        (pix_req),
    .pix_avail      (pix_avail),
    .pix_valid      (pix_valid),
    .pix_color      (pix_color),
    .cur_fmt        (cur_fmt),
    .pal_loaded     (pal_loaded)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] col(input int seed, input int i);
    col = 12'((i * 37 + seed * 101 + 5) & 12'hFFF);
  endfunction

  // each lane order is its own inverse, so reordering the wanted word gives the memory word
  function automatic logic [31:0] lanes(input logic [31:0] d, input logic [1:0] o);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      int s;
      case (o)
        2'd1: s = (k < 2) ? (k ^ 1) : k;
        2'd2: s = 3 - k;
        2'd3: s = k ^ 2;
        default: s = k;
      endcase
      r[8*k +: 8] = d[8*s +: 8];
    end
    lanes = r;
  endfunction

  function automatic logic [11:0] exp_color(input int ix);
    exp_color = (ix < exp_cnt) ? exp_pal[ix] : exp_pal[0];
  endfunction

  task automatic start_frame(input logic [1:0] mode);
    @(negedge clk);
    frame_start   = 1'b1;
    cfg_load_mode = mode;
    @(posedge clk);
    #1 frame_start = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, output logic loaded);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = lanes(w, cfg_lane_order);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    loaded   = pal_loaded;
    in_valid = 1'b0;
  endtask

  task automatic send_header(input logic [2:0] fmt, input int seed, input int nwords, input int full_len);
    for (int w = 0; w < nwords; w++) begin
      logic [15:0] lo, hi;
      logic        ld;
      lo = (w == 0) ? {1'b0, fmt, col(seed, 0)} : {4'h5, col(seed, 2*w)};
      hi = {4'hA, col(seed, 2*w + 1)};
      exp_pal[2*w]     = col(seed, 2*w);
      exp_pal[2*w + 1] = col(seed, 2*w + 1);
      exp_cnt = 2*w + 2;
      if (w == 0) exp_fmt = fmt;
      send_word({hi, lo}, ld);
      chk("R5 pal_loaded on header word", 32'(ld), 32'((w == full_len - 1) ? 1 : 0));
      if (w == 0) chk("R3 format code", 32'(cur_fmt), 32'(fmt));
    end
    if (nwords == full_len) begin
      @(posedge clk); #1;
      chk("R5 pulse width", 32'(pal_loaded), 32'd0);
    end
  endtask

  task automatic get_pixel(input string req, input logic [11:0] exp);
    @(negedge clk);
    chk({req, " pix_avail"}, 32'(pix_avail), 32'd1);
    pix_req = 1'b1;
    @(posedge clk);
    #1 pix_req = 1'b0;
    @(negedge clk);
    chk("R10 pix_valid after request", 32'(pix_valid), 32'd1);
    chk(req, 32'(pix_color), 32'(exp));
  endtask

  task automatic check_word(input string req, input logic [31:0] d);
    int step, n;
    logic ld;
    step = (exp_fmt == 0) ? 1 : (exp_fmt == 1) ? 2 : (exp_fmt == 2) ? 4 : (exp_fmt == 3) ? 8 : 16;
    n = 32 / step;
    send_word(d, ld);
    for (int k = 0; k < n; k++) begin
      logic [11:0] e;
      if (step == 16) e = d[16*k +: 12];
      else            e = exp_color(int'((d >> (k*step)) & ((1 << step) - 1)));
      get_pixel(req, e);
    end
    @(negedge clk);
    chk("R10 avail drops after last pixel", 32'(pix_avail), 32'd0);
  endtask

  task automatic ignored_request();
    @(negedge clk);
    chk("R10 no pixel available", 32'(pix_avail), 32'd0);
    pix_req = 1'b1;
    @(posedge clk);
    #1 pix_req = 1'b0;
    @(negedge clk);
    chk("R10 ignored request", 32'(pix_valid), 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 in_ready", 32'(in_ready), 32'd0);
    chk("R1 pix_avail", 32'(pix_avail), 32'd0);
    chk("R1 pix_valid", 32'(pix_valid), 32'd0);
    chk("R1 pal_loaded", 32'(pal_loaded), 32'd0);
    chk("R1 cur_fmt", 32'(cur_fmt), 32'd0);
    in_valid = 1'b1;
    pix_req  = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    pix_req  = 1'b0;
    @(negedge clk);
    chk("R1 request ignored", 32'(pix_valid), 32'd0);
    chk("R1 still not ready", 32'(in_ready), 32'd0);
  endtask

  task automatic t_4bpp();
    cfg_lane_order = 2'd0;
    start_frame(2'd0);
    send_header(3'd2, 1, 8, 8);
    check_word("R8 4bpp lsb first", 32'h7654_3210);
    check_word("R8 4bpp mixed", 32'hFEDC_A958);
    ignored_request();
  endtask

  task automatic t_lane_orders();
    for (int o = 1; o < 4; o++) begin
      cfg_lane_order = 2'(o);
      start_frame(2'd3);
      send_header(3'd0, 10 + o, 8, 8);
      check_word("R2 lane order 1bpp", 32'h0F3C_A501);
    end
    cfg_lane_order = 2'd0;
  endtask

  task automatic t_8bpp();
    start_frame(2'd0);
    send_header(3'd3, 3, 128, 128);
    check_word("R4 8bpp data after long header", 32'hFF80_3F01);
    check_word("R8 8bpp indices", 32'h7E81_02C4);
  endtask

  task automatic t_direct();
    start_frame(2'd0);
    send_header(3'd4, 4, 8, 8);
    check_word("R9 direct colour", 32'hF123_A456);
    start_frame(2'd0);
    send_header(3'd6, 5, 8, 8);
    check_word("R3 code 6 is direct", 32'h0ABC_9DEF);
  endtask

  task automatic t_pal_then_data();
    start_frame(2'd1);
    send_header(3'd1, 6, 8, 8);
    repeat (3) @(negedge clk);
    chk("R6 not ready after palette-only header", 32'(in_ready), 32'd0);
    chk("R6 no pixels after palette-only header", 32'(pix_avail), 32'd0);
    start_frame(2'd2);
    @(negedge clk);
    chk("R7 format kept", 32'(cur_fmt), 32'd1);
    chk("R7 ready for data at once", 32'(in_ready), 32'd1);
    check_word("R7 data-only reuses palette", 32'hE4E4_1B93);
    chk("R7 no load pulse", 32'(pal_loaded), 32'd0);
  endtask

  task automatic t_abort();
    start_frame(2'd0);
    send_header(3'd3, 7, 5, 128);
    start_frame(2'd2);
    @(negedge clk);
    chk("R12 aborted header keeps format", 32'(cur_fmt), 32'd3);
    check_word("R11 index past loaded count", 32'h05C8_0A09);
  endtask

  task automatic t_flush_word();
    logic ld;
    start_frame(2'd0);
    send_header(3'd2, 8, 8, 8);
    send_word(32'h1111_2345, ld);
    get_pixel("R12 pixel before abort", exp_color(5));
    get_pixel("R12 pixel before abort", exp_color(4));
    start_frame(2'd2);
    @(negedge clk);
    chk("R12 buffered word dropped", 32'(pix_avail), 32'd0);
    check_word("R12 new word from first pixel", 32'h89AB_CDEF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_4bpp();
    t_lane_orders();
    t_8bpp();
    t_direct();
    t_pal_then_data();
    t_abort();
    t_flush_word();
    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule